// File: doc/BRIEF.md
# Ethernet receive frame admission filter

This block sits behind the receive MAC of one switch port and decides, frame by frame, whether a received Ethernet frame may be written into the switch buffer or must be thrown away. It watches the incoming byte stream as a sequence of byte beats. The preamble is already stripped. Start and end markers ride on the first and last beats. It keeps a running byte count, and it raises a jabber flag while a frame is still arriving once that frame has clearly overrun its allowed length.

The length ceiling depends on a per-port mode bit and on whether a VLAN tag will be added later in the pipeline. The standard mode caps the received length at the 802.3 maximum of 1518 bytes. The extended mode allows up to 1535 bytes, or 4 bytes fewer when a tag is to be inserted, so that a stored frame never exceeds 1535 bytes. Upstream error flags for CRC, alignment and jabber are sampled with the last beat.

One clock after the last beat the block emits a single-cycle verdict: accept or discard, a reason code, and at most one statistics increment pulse.

Top module: `rx_admit_filter`

## Requirements
- R1: `byte_count` holds the number of beats of the current frame seen so far. It becomes 1 on the clock edge that samples a start beat (`rx_valid` and `rx_sof`), and it rises by one on each further `rx_valid` beat. After reset it is 0.
- R2: The byte count saturates at 2^CNT_W-1 (2047 by default) and never wraps back to a small value.
- R3: A verdict appears one clock after the edge that samples the end beat (`rx_valid` and `rx_eof`). `vd_valid` is high for exactly that one cycle. `vd_accept` is 1 for a kept frame. `vd_reason` is encoded as 0 none, 1 short, 2 long, 3 CRC, 4 alignment, 5 jabber.
- R4: With `cfg_std_max`=0 and `cfg_tag_add`=0, frames of up to 1535 bytes pass the length test, and 1536 bytes is discarded as long.
- R5: With `cfg_std_max`=0 and `cfg_tag_add`=1, the limit is 1531 bytes, and 1532 is discarded as long.
- R6: With `cfg_std_max`=1, the limit is 1518 bytes whatever `cfg_tag_add` is. Both configuration inputs are taken on the start beat and held for the whole frame.
- R7: Frames shorter than 64 bytes are discarded with reason short. A 64-byte frame passes.
- R8: `rx_err_crc`, `rx_err_align` or `rx_err_jabber` high on the end beat discards the frame, with reason CRC, alignment or jabber respectively, and pulses `stat_err`.
- R9: `jabber_active` rises on the edge where the count first exceeds the active limit plus JAB_MARGIN (32 by default), before the frame ends. It stays high until the next start beat clears it. Such a frame is discarded with reason jabber.
- R10: When several reasons apply, the priority is short, then jabber, then long, then CRC, then alignment. Exactly one of `stat_short`, `stat_long`, `stat_err` pulses with a discard verdict. A short or long reason pulses `stat_short` or `stat_long`, and any other discard pulses `stat_err`. None of them pulses on an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One received byte present this cycle |
| rx_sof | input | 1 | This beat is the first byte of a frame |
| rx_eof | input | 1 | This beat is the last byte of a frame |
| cfg_std_max | input | 1 | 1 selects the standard 1518-byte limit, 0 the extended one |
| cfg_tag_add | input | 1 | A VLAN tag will be inserted into this frame |
| rx_err_crc | input | 1 | Upstream CRC error, sampled on the end beat |
| rx_err_align | input | 1 | Upstream alignment error, sampled on the end beat |
| rx_err_jabber | input | 1 | Upstream jabber error, sampled on the end beat |
| vd_valid | output | 1 | Verdict pulse |
| vd_accept | output | 1 | Frame is to be stored |
| vd_reason | output | 3 | Discard reason code |
| byte_count | output | CNT_W | Running byte count of the current frame |
| jabber_active | output | 1 | Current frame has overrun limit plus margin |
| stat_short | output | 1 | Increment the short-frame counter |
| stat_long | output | 1 | Increment the long-frame counter |
| stat_err | output | 1 | Increment the errored-frame counter |

## Verification
The bench builds the block with its default parameters: an 11-bit counter, a 64-byte minimum, limits of 1518 and 1535 with 4 tag bytes, and a 32-byte jabber margin. With these values every length boundary can be reached with real frame lengths. So can the jabber threshold at 1551 bytes in standard mode. Counter saturation at 2047 bytes is reached by a frame of a little over two thousand beats, so no shrunken parameters are needed to cover it.

// File: rtl/rx_admit_pkg.sv
// Shared definitions for the receive admission filter.
// Reason codes are part of the verdict interface and must not be renumbered.
package rx_admit_pkg;
    typedef enum logic [2:0] {
        RSN_NONE   = 3'd0,
        RSN_SHORT  = 3'd1,
        RSN_LONG   = 3'd2,
        RSN_CRC    = 3'd3,
        RSN_ALIGN  = 3'd4,
        RSN_JABBER = 3'd5
    } reason_e;
endpackage

// File: rtl/rx_len_counter.sv
// Frame byte counter, limit selection and jabber timer.
// Counts one byte per valid beat, saturating at all-ones. It latches the length
// limit on the start beat and raises a sticky jabber flag once the count passes
// limit + JAB_MARGIN. Assumes a start beat precedes every frame's other beats.
module rx_len_counter #(
    parameter int CNT_W      = 11,
    parameter int STD_MAX    = 1518,
    parameter int EXT_MAX    = 1535,
    parameter int TAG_BYTES  = 4,
    parameter int JAB_MARGIN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  logic             beat_sof,
    input  logic             cfg_std,
    input  logic             cfg_tag,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] len_now,
    output logic [CNT_W:0]   limit_now,
    output logic             jab_q,
    output logic             jab_now
);
    localparam logic [CNT_W-1:0] CMAX    = {CNT_W{1'b1}};
    localparam logic [CNT_W:0]   LIM_STD = (CNT_W+1)'(STD_MAX);
    localparam logic [CNT_W:0]   LIM_EXT = (CNT_W+1)'(EXT_MAX);
    localparam logic [CNT_W:0]   LIM_TAG = (CNT_W+1)'(EXT_MAX - TAG_BYTES);
    localparam logic [CNT_W:0]   MARGIN  = (CNT_W+1)'(JAB_MARGIN);

    logic           start_beat;
    logic [CNT_W:0] lim_sel;
    logic [CNT_W:0] lim_q;
    logic [CNT_W:0] jab_thr;

    assign start_beat = beat_valid && beat_sof;

    // Pick the limit from the configuration presented with the start beat.
    always_comb begin
        if (cfg_std)      lim_sel = LIM_STD;
        else if (cfg_tag) lim_sel = LIM_TAG;
        else              lim_sel = LIM_EXT;
    end

    assign limit_now = start_beat ? lim_sel : lim_q;
    assign jab_thr   = limit_now + MARGIN;

    // Count after the current beat, saturating at the top value.
    always_comb begin
        if (!beat_valid)          len_now = count_q;
        else if (beat_sof)        len_now = CNT_W'(1);
        else if (count_q == CMAX) len_now = CMAX;
        else                      len_now = count_q + CNT_W'(1);
    end

    // Jabber flag including this beat: restarts on a start beat, then sticks.
    always_comb begin
        if (!beat_valid) jab_now = jab_q;
        else             jab_now = (beat_sof ? 1'b0 : jab_q) || ({1'b0, len_now} > jab_thr);
    end

    // Register count, latched limit and jabber flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            lim_q   <= LIM_EXT;
            jab_q   <= 1'b0;
        end else begin
            count_q <= len_now;
            jab_q   <= jab_now;
            if (start_beat) lim_q <= lim_sel;
        end
    end

    p_sof_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_beat |=> (count_q == CNT_W'(1)));
    p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_sof && count_q == CMAX) |=> (count_q == CMAX));
    p_jab_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_beat |=> !jab_q);
    p_jab_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_q && !start_beat) |=> jab_q);
endmodule

// File: rtl/rx_verdict.sv
// End-of-frame classifier.
// On the end beat it ranks the discard reasons (short, jabber, long, CRC,
// alignment) and registers a one-cycle verdict plus one statistics pulse.
// Assumes the length, limit and jabber inputs already include the end beat.
module rx_verdict
    import rx_admit_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eof_beat,
    input  logic [CNT_W-1:0] len_now,
    input  logic [CNT_W:0]   limit_now,
    input  logic             jab_now,
    input  logic             err_crc,
    input  logic             err_align,
    input  logic             err_jab,
    output logic             v_valid,
    output logic             v_accept,
    output reason_e          v_reason,
    output logic             s_short,
    output logic             s_long,
    output logic             s_err
);
    localparam logic [CNT_W:0] MIN_L = (CNT_W+1)'(MIN_LEN);

    reason_e rsn;
    logic    is_short;
    logic    is_long;

    assign is_short = {1'b0, len_now} < MIN_L;
    assign is_long  = {1'b0, len_now} > limit_now;

    // Rank the discard reasons; the first one that applies wins.
    always_comb begin
        if (is_short)               rsn = RSN_SHORT;
        else if (jab_now || err_jab) rsn = RSN_JABBER;
        else if (is_long)           rsn = RSN_LONG;
        else if (err_crc)           rsn = RSN_CRC;
        else if (err_align)         rsn = RSN_ALIGN;
        else                        rsn = RSN_NONE;
    end

    // Register the verdict and the matching statistics pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_valid  <= 1'b0;
            v_accept <= 1'b0;
            v_reason <= RSN_NONE;
            s_short  <= 1'b0;
            s_long   <= 1'b0;
            s_err    <= 1'b0;
        end else begin
            v_valid  <= eof_beat;
            v_accept <= eof_beat && (rsn == RSN_NONE);
            v_reason <= eof_beat ? rsn : RSN_NONE;
            s_short  <= eof_beat && (rsn == RSN_SHORT);
            s_long   <= eof_beat && (rsn == RSN_LONG);
            s_err    <= eof_beat && (rsn == RSN_CRC || rsn == RSN_ALIGN || rsn == RSN_JABBER);
        end
    end

    p_verdict_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        v_valid |-> $past(eof_beat));
    p_one_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_short, s_long, s_err}));
    p_accept_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (v_valid && v_accept) |-> !(s_short || s_long || s_err));
    p_stat_on_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_short || s_long || s_err) |-> (v_valid && !v_accept));
endmodule

// File: rtl/rx_admit_filter.sv
// Receive frame admission filter, top level.
// Takes a preamble-stripped byte-beat stream with start and end markers and
// produces a store/discard verdict one clock after each end beat, plus a
// running count, a live jabber flag and statistics increment pulses.
// Assumes frames do not overlap and configuration is valid on the start beat.
module rx_admit_filter
    import rx_admit_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int MIN_LEN    = 64,
    parameter int STD_MAX    = 1518,
    parameter int EXT_MAX    = 1535,
    parameter int TAG_BYTES  = 4,
    parameter int JAB_MARGIN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             cfg_std_max,
    input  logic             cfg_tag_add,
    input  logic             rx_err_crc,
    input  logic             rx_err_align,
    input  logic             rx_err_jabber,
    output logic             vd_valid,
    output logic             vd_accept,
    output logic [2:0]       vd_reason,
    output logic [CNT_W-1:0] byte_count,
    output logic             jabber_active,
    output logic             stat_short,
    output logic             stat_long,
    output logic             stat_err
);
    logic [CNT_W-1:0] len_now;
    logic [CNT_W:0]   limit_now;
    logic             jab_now;
    reason_e          reason_q;

    rx_len_counter #(
        .CNT_W(CNT_W), .STD_MAX(STD_MAX), .EXT_MAX(EXT_MAX),
        .TAG_BYTES(TAG_BYTES), .JAB_MARGIN(JAB_MARGIN)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .beat_valid(rx_valid), .beat_sof(rx_sof),
        .cfg_std(cfg_std_max), .cfg_tag(cfg_tag_add),
        .count_q(byte_count), .len_now(len_now), .limit_now(limit_now),
        .jab_q(jabber_active), .jab_now(jab_now)
    );

    rx_verdict #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_vd (
        .clk(clk), .rst_n(rst_n),
        .eof_beat(rx_valid && rx_eof),
        .len_now(len_now), .limit_now(limit_now), .jab_now(jab_now),
        .err_crc(rx_err_crc), .err_align(rx_err_align), .err_jab(rx_err_jabber),
        .v_valid(vd_valid), .v_accept(vd_accept), .v_reason(reason_q),
        .s_short(stat_short), .s_long(stat_long), .s_err(stat_err)
    );

    assign vd_reason = reason_q;

    p_accept_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vd_valid |-> (vd_accept == (vd_reason == 3'd0)));
endmodule

// File: tb/sim_rx_admit_filter.sv
module sim_rx_admit_filter;
    localparam int CLK_PERIOD = 10;
    localparam int CMAX = 2047;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
    logic cfg_std_max = 0, cfg_tag_add = 0;
    logic rx_err_crc = 0, rx_err_align = 0, rx_err_jabber = 0;
    logic vd_valid, vd_accept, jabber_active, stat_short, stat_long, stat_err;
    logic [2:0] vd_reason;
    logic [10:0] byte_count;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_admit_filter u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .cfg_std_max(cfg_std_max), .cfg_tag_add(cfg_tag_add),
        .rx_err_crc(rx_err_crc), .rx_err_align(rx_err_align), .rx_err_jabber(rx_err_jabber),
        .vd_valid(vd_valid), .vd_accept(vd_accept), .vd_reason(vd_reason),
        .byte_count(byte_count), .jabber_active(jabber_active),
        .stat_short(stat_short), .stat_long(stat_long), .stat_err(stat_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bench model of the requirements: 0 none,1 short,2 long,3 crc,4 align,5 jabber.
    function automatic int model_reason(int len, bit std, bit tag, bit crc, bit al, bit jb);
        int lim;
        int slen;
        lim = std ? 1518 : (tag ? 1531 : 1535);
        slen = (len > CMAX) ? CMAX : len;
        if (slen < 64) return 1;
        if (jb || slen > lim + 32) return 5;
        if (slen > lim) return 2;
        if (crc) return 3;
        if (al) return 4;
        return 0;
    endfunction

    // Drive one frame and check count trace, verdict, stats and pulse width.
    task automatic frame(input string req, input int len, input bit std, input bit tag,
                         input bit crc, input bit al, input bit jb, input bit flip,
                         output int jab_first, output bit jab_at1);
        int cnt_bad = 0, cnt_act = 0, cnt_exp = 0;
        int exp_r;
        int v, a, r, ss, sl, se;
        jab_first = 0;
        jab_at1 = 0;
        exp_r = model_reason(len, std, tag, crc, al, jb);
        cfg_std_max = std;
        cfg_tag_add = tag;
        for (int i = 1; i <= len; i++) begin
            rx_valid = 1;
            rx_sof = (i == 1);
            rx_eof = (i == len);
            rx_err_crc = (i == len) && crc;
            rx_err_align = (i == len) && al;
            rx_err_jabber = (i == len) && jb;
            if (flip && i == 10) cfg_std_max = ~std;
            @(negedge clk);
            if (int'(byte_count) != ((i > CMAX) ? CMAX : i) && cnt_bad == 0) begin
                cnt_bad = 1;
                cnt_act = int'(byte_count);
                cnt_exp = (i > CMAX) ? CMAX : i;
            end
            if (i == 1) jab_at1 = jabber_active;
            if (jabber_active && jab_first == 0) jab_first = i;
        end
        v = vd_valid; a = vd_accept; r = vd_reason;
        ss = stat_short; sl = stat_long; se = stat_err;
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        rx_err_crc = 0; rx_err_align = 0; rx_err_jabber = 0;
        cfg_std_max = std;
        check(cnt_bad == 0, {req, " R1 R2 count trace"}, cnt_act, cnt_exp);
        check(v == 1, {req, " R3 verdict valid"}, v, 1);
        check(a == (exp_r == 0), {req, " R3 accept"}, a, int'(exp_r == 0));
        check(r == exp_r, {req, " reason"}, r, exp_r);
        check(ss == (exp_r == 1) && sl == (exp_r == 2) && se == (exp_r >= 3),
              {req, " R10 stat pulses"}, ss*4 + sl*2 + se,
              (exp_r == 1) * 4 + (exp_r == 2) * 2 + int'(exp_r >= 3));
        @(negedge clk);
        check(vd_valid == 0 && !stat_short && !stat_long && !stat_err,
              {req, " R3 single-cycle verdict"}, vd_valid, 0);
    endtask

    task automatic t_reset();
        check(byte_count == 0 && !vd_valid && !jabber_active, "R1 R3 reset state",
              int'(byte_count) + vd_valid + jabber_active, 0);
        check(!stat_short && !stat_long && !stat_err, "R10 reset stats", stat_short + stat_long + stat_err, 0);
    endtask

    task automatic t_short();
        int jf; bit j1;
        frame("R7 63B", 63, 0, 0, 0, 0, 0, 0, jf, j1);
        frame("R7 64B", 64, 0, 0, 0, 0, 0, 0, jf, j1);
        frame("R7 1B", 1, 0, 0, 0, 0, 0, 0, jf, j1);
    endtask

    task automatic t_ext_notag();
        int jf; bit j1;
        frame("R4 1535B", 1535, 0, 0, 0, 0, 0, 0, jf, j1);
        frame("R4 1536B", 1536, 0, 0, 0, 0, 0, 0, jf, j1);
    endtask

    task automatic t_ext_tag();
        int jf; bit j1;
        frame("R5 1531B", 1531, 0, 1, 0, 0, 0, 0, jf, j1);
        frame("R5 1532B", 1532, 0, 1, 0, 0, 0, 0, jf, j1);
    endtask

    task automatic t_std();
        int jf; bit j1;
        frame("R6 1518B", 1518, 1, 0, 0, 0, 0, 0, jf, j1);
        frame("R6 1519B", 1519, 1, 0, 0, 0, 0, 0, jf, j1);
        frame("R6 tag 1518B", 1518, 1, 1, 0, 0, 0, 0, jf, j1);
        frame("R6 tag 1519B", 1519, 1, 1, 0, 0, 0, 0, jf, j1);
        // Mode flips to extended mid-frame: the latched standard limit must still apply.
        frame("R6 latched limit", 1530, 1, 0, 0, 0, 0, 1, jf, j1);
    endtask

    task automatic t_errors();
        int jf; bit j1;
        frame("R8 crc", 100, 0, 0, 1, 0, 0, 0, jf, j1);
        frame("R8 align", 100, 0, 0, 0, 1, 0, 0, jf, j1);
        frame("R8 ext jabber", 100, 0, 0, 0, 0, 1, 0, jf, j1);
    endtask

    task automatic t_jabber();
        int jf; bit j1;
        frame("R9 overrun", 1560, 1, 0, 0, 0, 0, 0, jf, j1);
        check(jf == 1551, "R9 jabber rises at limit+margin+1", jf, 1551);
        frame("R9 next frame", 64, 1, 0, 0, 0, 0, 0, jf, j1);
        check(j1 == 0 && jf == 0, "R9 jabber cleared by start", jf + j1, 0);
        frame("R9 ext below thr", 1567, 0, 0, 0, 0, 0, 0, jf, j1);
        check(jf == 0, "R9 no jabber at 1567 ext", jf, 0);
    endtask

    task automatic t_priority();
        int jf; bit j1;
        frame("R10 short over errors", 40, 0, 0, 1, 1, 1, 0, jf, j1);
        frame("R10 long over crc", 1530, 1, 0, 1, 0, 0, 0, jf, j1);
        frame("R10 crc over align", 100, 0, 0, 1, 1, 0, 0, jf, j1);
        frame("R10 jabber over long", 1600, 1, 0, 1, 0, 0, 0, jf, j1);
    endtask

    task automatic t_saturate();
        int jf; bit j1;
        frame("R2 saturate", 2100, 0, 0, 0, 0, 0, 0, jf, j1);
        check(jf == 1568, "R2 R9 jabber on saturating frame", jf, 1568);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_short();
        t_ext_notag();
        t_ext_tag();
        t_std();
        t_errors();
        t_jabber();
        t_priority();
        t_saturate();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule